// File: doc/BRIEF.md
# Read-First RAM Wrapper

This block wraps a single-clock storage array so that a registered read always returns the contents that were present before any write issued on the same rising edge. The write is not applied directly. Its address, data and per-bit mask are first registered on the rising clock edge. The registered write is then committed to the array on the next falling edge. The read port samples the array on the rising edge, so it sees the array as it was before that edge's write. The write issued in cycle k is visible to a read issued in cycle k+1.

The read and write sides share one clock. A write touches only the bits selected by its mask, and an all-zero mask is a no-op. The parameter `ZERO_INIT` controls power-up. When it is set, reset clears the array and the registered write mask, so nothing is written at start-up. When it is clear, neither the array nor the registered mask has a defined start value. The parameter `PORT_REL` states how the write port relates to the read port. Any value other than read-first stops elaboration with an error. Transparent behaviour is therefore rejected, and the array itself works with no defined ordering between its read and write.

Top module: `rdfirst_ram`

## Requirements
- R1: While reset is asserted, and on the first rising edge after it is released, `rd_data_o` is zero.
- R2: A read issued on the same rising edge as a write to the same address returns the word stored before that write.
- R3: A write issued in cycle k is returned by a read of that address issued in cycle k+1 or later.
- R4: A write changes exactly the bits where `wr_mask_i` is 1, taking them from `wr_data_i`. Bits where the mask is 0 keep their old value. An all-zero mask leaves the word unchanged.
- R5: With `ZERO_INIT` = 1, after reset every word reads as zero, and no write takes place until a nonzero mask is applied.
- R6: When `rd_en_i` is 0, `rd_data_o` keeps its previous value.
- R7: The write that reaches the array uses the address, data and mask present at the capturing rising edge. Changing those inputs after that edge does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared read/write clock; rising edge captures, falling edge commits |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_addr_i | input | ADDR_W | Write word address |
| wr_data_i | input | DATA_W | Write data |
| wr_mask_i | input | DATA_W | Per-bit write select, 1 = write that bit |
| rd_addr_i | input | ADDR_W | Read word address |
| rd_en_i | input | 1 | Read enable; 0 holds the output |
| rd_data_o | output | DATA_W | Registered read data |

## Verification
On every cycle, the assertions check four things. The read register loads the array word as it was before the edge. A disabled read holds the output. The write register holds the inputs from the previous edge. After each falling-edge commit, the masked bits of the captured word are present in the array. Some behaviours can be shown only by the bench's scenarios, which compare the read data with an independent model over sequences of writes and reads. These are that unmasked bits survive a write, that same-cycle and next-cycle reads of one address give the old and the new value respectively, that the array is zero after reset, and that input changes after the capture edge have no effect.

// File: rtl/rdfirst_pkg.sv
package rdfirst_pkg;

    // Ordering of the read port relative to the write port
    typedef enum logic [1:0] {
        REL_NONE        = 2'd0,
        REL_READ_FIRST  = 2'd1,
        REL_TRANSPARENT = 2'd2
    } rel_e;

endpackage

// File: rtl/rdfirst_wcap.sv
// Rising-edge capture of the write command.
module rdfirst_wcap #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter bit ZERO_INIT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [DATA_W-1:0] mask_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
    } wcap_t;

    wcap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.addr = addr_i;
        cap_d.data = data_i;
        cap_d.mask = mask_i;
    end

    generate
        if (ZERO_INIT) begin : g_mask_rst
            // Mask powers up cleared: no write lands at start-up
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cap_q <= '0;
                end else begin
                    cap_q <= cap_d;
                end
            end
        end else begin : g_mask_free
            // Array content is undefined anyway: leave the mask unreset
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    cap_q.addr <= '0;
                    cap_q.data <= '0;
                end else begin
                    cap_q <= cap_d;
                end
            end
        end
    endgenerate

    assign addr_o = cap_q.addr;
    assign data_o = cap_q.data;
    assign mask_o = cap_q.mask;

endmodule

// File: rtl/rdfirst_array.sv
// Storage committed on the falling edge with a per-bit mask.
module rdfirst_array #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 16,
    parameter bit ZERO_INIT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] wr_mask_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_word_o,
    output logic [DATA_W-1:0] wr_word_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] word_d;

    always_comb begin
        word_d = (mem_q[wr_addr_i] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end

    generate
        if (ZERO_INIT) begin : g_clear
            always_ff @(negedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        mem_q[i] <= '0;
                    end
                end else begin
                    mem_q[wr_addr_i] <= word_d;
                end
            end
        end else begin : g_noclear
            always_ff @(negedge clk_i) begin
                mem_q[wr_addr_i] <= word_d;
            end
        end
    endgenerate

    assign rd_word_o = mem_q[rd_addr_i];
    assign wr_word_o = mem_q[wr_addr_i];

endmodule

// File: rtl/rdfirst_rport.sv
// Registered read with enable.
module rdfirst_rport #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (en_i) begin
            rd_d.data = word_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign data_o = rd_q.data;

endmodule

// File: rtl/rdfirst_ram.sv
// Read-first wrapper: write retimed to the falling edge.
module rdfirst_ram #(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter bit                ZERO_INIT = 1'b1,
    parameter rdfirst_pkg::rel_e PORT_REL  = rdfirst_pkg::REL_READ_FIRST
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] wr_mask_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        if (PORT_REL != rdfirst_pkg::REL_READ_FIRST) begin : g_bad_rel
            $error("rdfirst_ram: write port must be read-first toward its read port");
        end
    endgenerate

    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] cap_mask;
    logic [DATA_W-1:0] arr_rd_word;
    logic [DATA_W-1:0] arr_wr_word;

    rdfirst_wcap #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .ZERO_INIT (ZERO_INIT)
    ) i_wcap (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .addr_i (wr_addr_i),
        .data_i (wr_data_i),
        .mask_i (wr_mask_i),
        .addr_o (cap_addr),
        .data_o (cap_data),
        .mask_o (cap_mask)
    );

    rdfirst_array #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .ZERO_INIT (ZERO_INIT)
    ) i_array (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_addr_i (cap_addr),
        .wr_data_i (cap_data),
        .wr_mask_i (cap_mask),
        .rd_addr_i (rd_addr_i),
        .rd_word_o (arr_rd_word),
        .wr_word_o (arr_wr_word)
    );

    rdfirst_rport #(
        .DATA_W (DATA_W)
    ) i_rport (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (rd_en_i),
        .word_i (arr_rd_word),
        .data_o (rd_data_o)
    );

endmodule

// File: rtl/rdfirst_ram_chk.sv
module rdfirst_ram_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] wr_mask_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [DATA_W-1:0] cap_data,
    input logic [DATA_W-1:0] cap_mask,
    input logic [DATA_W-1:0] arr_rd_word,
    input logic [DATA_W-1:0] arr_wr_word
);

    a_r1_zero_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> rd_data_o == '0);

    a_r2_reads_old_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_en_i |=> rd_data_o == $past(arr_rd_word));

    a_r4_masked_bits_land: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arr_wr_word & cap_mask) == (cap_data & cap_mask));

    a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

    a_r7_capture_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cap_addr == $past(wr_addr_i)) && (cap_data == $past(wr_data_i))
                 && (cap_mask == $past(wr_mask_i)));

endmodule

bind rdfirst_ram rdfirst_ram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .wr_mask_i   (wr_mask_i),
    .rd_en_i     (rd_en_i),
    .rd_data_o   (rd_data_o),
    .cap_addr    (cap_addr),
    .cap_data    (cap_data),
    .cap_mask    (cap_mask),
    .arr_rd_word (arr_rd_word),
    .arr_wr_word (arr_wr_word)
);

// File: tb/test_rdfirst_ram.sv
`timescale 1ns/1ps
module test_rdfirst_ram;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic [DW-1:0] wm;
        logic [AW-1:0] ra;
        logic          ren;
    } vec_t;

    // Covers R2 R3 R4 R6 with address boundaries 0 and 15
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd3,  8'hAA, 8'hFF, 4'd3,  1'b1},
        '{4'd0,  8'h00, 8'h00, 4'd3,  1'b1},
        '{4'd3,  8'h55, 8'hF0, 4'd3,  1'b1},
        '{4'd7,  8'hC3, 8'hFF, 4'd3,  1'b1},
        '{4'd7,  8'h00, 8'h00, 4'd7,  1'b1},
        '{4'd7,  8'hFF, 8'h0C, 4'd7,  1'b0},
        '{4'd0,  8'h00, 8'h00, 4'd7,  1'b1},
        '{4'd15, 8'h81, 8'hFF, 4'd15, 1'b1},
        '{4'd0,  8'h7E, 8'hFF, 4'd15, 1'b1},
        '{4'd0,  8'h00, 8'h00, 4'd0,  1'b1},
        '{4'd0,  8'hFF, 8'h00, 4'd0,  1'b1},
        '{4'd0,  8'h00, 8'h00, 4'd0,  1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [DW-1:0] wd = '0;
    logic [DW-1:0] wm = '0;
    logic [AW-1:0] ra = '0;
    logic          ren = 1'b0;
    logic [DW-1:0] rd;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [NW];
    logic [DW-1:0] exp_rd;

    always #5 clk = ~clk;

    rdfirst_ram #(.ADDR_W(AW), .DATA_W(DW)) i_rdfirst_ram (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_addr_i (wa),
        .wr_data_i (wd),
        .wr_mask_i (wm),
        .rd_addr_i (ra),
        .rd_en_i   (ren),
        .rd_data_o (rd)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle: model read before model write, then sample after the edge
    task automatic step(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] m,
                        input logic [AW-1:0] r, input logic e);
        wa = a; wd = d; wm = m; ra = r; ren = e;
        if (e) exp_rd = model[r];
        model[a] = (model[a] & ~m) | (d & m);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wa = '0; wd = '0; wm = '0; ra = '0; ren = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = '0;
        exp_rd = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 during reset", rd, '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after release", rd, '0);
    endtask

    initial begin
        do_reset();

        // R5: every word zero after reset, idle cycles write nothing
        for (int i = 0; i < NW; i++) begin
            step('0, 8'hFF, 8'h00, AW'(i), 1'b1);
            check("R5 zero after reset", rd, 8'h00);
        end

        // Table walk (R2 R3 R4 R6)
        for (int v = 0; v < NV; v++) begin
            step(VEC[v].wa, VEC[v].wd, VEC[v].wm, VEC[v].ra, VEC[v].ren);
            check($sformatf("R2 R3 R4 R6 table[%0d]", v), rd, exp_rd);
        end

        // R2 directed: same-edge read of written word returns old 5A
        step(4'd3, 8'h11, 8'hFF, 4'd3, 1'b1);
        check("R2 same edge old", rd, 8'h5A);
        // R3 directed: next cycle sees 11
        step(4'd0, 8'h00, 8'h00, 4'd3, 1'b1);
        check("R3 next cycle new", rd, 8'h11);

        // R4: unmasked bits survive, only bit 7 flips
        step(4'd9, 8'hFF, 8'h80, 4'd0, 1'b0);
        step(4'd0, 8'h00, 8'h00, 4'd9, 1'b1);
        check("R4 single bit", rd, 8'h80);

        // R7: inputs changed right after capture edge do not alter the write
        wa = 4'd5; wd = 8'h3C; wm = 8'hFF; ra = 4'd0; ren = 1'b0;
        model[5] = 8'h3C;
        @(posedge clk);
        #1;
        wa = 4'd5; wd = 8'hE7; wm = 8'h00;
        @(posedge clk);
        #1;
        step(4'd0, 8'h00, 8'h00, 4'd5, 1'b1);
        check("R7 captured write", rd, 8'h3C);

        // R6: disabled read holds across several different addresses
        step(4'd0, 8'h00, 8'h00, 4'd9, 1'b0);
        step(4'd0, 8'h00, 8'h00, 4'd3, 1'b0);
        check("R6 hold", rd, 8'h3C);

        // R5: re-reset clears written words
        do_reset();
        step(4'd0, 8'h00, 8'h00, 4'd5, 1'b1);
        check("R5 cleared by reset", rd, 8'h00);
        step(4'd0, 8'h00, 8'h00, 4'd15, 1'b1);
        check("R5 cleared by reset", rd, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule